// File: doc/BRIEF.md
# Precision-time frame classifier and timestamp tagger

This block sits on both directions of the byte stream between user logic and an Ethernet MAC. Every frame passes through unchanged. While a frame goes by, the block reads its EtherType and the precision-time header that follows it. From that header it forms a 20-bit fingerprint made of the message type and the sequence number. The fingerprint lets software match each hardware timestamp to the packet it belongs to.

On the transmit side, the block gives the MAC the fingerprint and a timestamp-request line for every frame. A configuration input chooses between two transmit modes. In one mode only precision-time frames ask for a stamp. In the other mode every frame asks for one. In both modes a Delay_Resp message never asks, because its body already carries the master's receive time.

On the receive side, the block samples the ingress timestamp that the MAC supplies with the first byte of a frame. At the end of a qualifying precision-time frame it writes one entry, `{fingerprint, timestamp}`, into a small FIFO. Software learns that entries are waiting from a level interrupt. If the FIFO is full, the new entry is dropped and a sticky overflow flag is set.

Top module: `ptp_tagger`

## Requirements
- R1: On the transmit path, data, valid and last pass from input to output unchanged in the same cycle. The ready signal from the MAC is returned to user logic unchanged.
- R2: On the receive path, data, valid and last pass from input to output unchanged in the same cycle.
- R3: Frame byte positions are counted from 0, and only beats with valid high (and, on transmit, ready high) are counted. A frame counts as precision-time when bytes 12 and 13 hold 0x88 and 0xF7. The message type is the low nibble of byte 14: 0x0 is Sync, 0x1 is Delay_Req, 0x8 is Follow_Up and 0x9 is Delay_Resp. The sequence number is byte 44 (high byte) followed by byte 45.
- R4: For a precision-time frame, `tx_fp_valid` is high while bytes 48 up to the last byte are presented. During that time `tx_fp` equals `{type, sequence}` and stays stable. Both return to zero after the last byte is accepted. For other frames `tx_fp_valid` stays low.
- R5: When `tx_stamp_all` is 0, `tx_ts_req` is high while bytes 48 up to the last byte are presented, but only for precision-time frames whose type is not 0x9. For every other frame it stays low.
- R6: When `tx_stamp_all` is 1, `tx_ts_req` is high while bytes 48 up to the last byte are presented, for every frame except a precision-time frame of type 0x9.
- R7: A received precision-time frame whose type is not 0x9 and that has at least 49 bytes writes exactly one FIFO entry when its last byte arrives. The entry is `{type, sequence, ts}`, where `ts` is the value of `rx_ts` at the frame's first byte. The following frames write nothing: non-precision-time frames, type 0x9 frames, and frames shorter than 49 bytes.
- R8: The FIFO returns entries in arrival order. The oldest entry is shown on `evt_fp` and `evt_time`, and a pulse on `evt_pop` removes it.
- R9: `evt_irq` is high exactly when the FIFO holds at least one entry.
- R10: An entry that arrives while the FIFO is full is discarded, and the earlier entries are kept. The discard sets `evt_ovf`, which stays set until `evt_ovf_clr` is pulsed.
- R11: A transmit beat with ready low does not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_stamp_all | input | 1 | 1: request a stamp for every frame; 0: for precision-time frames only |
| tx_in_data | input | 8 | Transmit byte from user logic |
| tx_in_valid | input | 1 | Transmit byte valid |
| tx_in_last | input | 1 | Last byte of the transmit frame |
| tx_in_ready | output | 1 | Ready returned to user logic |
| tx_out_data | output | 8 | Transmit byte to the MAC |
| tx_out_valid | output | 1 | Transmit valid to the MAC |
| tx_out_last | output | 1 | Transmit last to the MAC |
| tx_out_ready | input | 1 | MAC ready |
| tx_fp_valid | output | 1 | Transmit fingerprint valid |
| tx_fp | output | 20 | Transmit fingerprint {type, sequence} |
| tx_ts_req | output | 1 | Timestamp request to the MAC |
| rx_in_data | input | 8 | Receive byte from the MAC |
| rx_in_valid | input | 1 | Receive byte valid |
| rx_in_last | input | 1 | Last byte of the receive frame |
| rx_ts | input | TS_W | Ingress timestamp, sampled at the first byte |
| rx_out_data | output | 8 | Receive byte to user logic |
| rx_out_valid | output | 1 | Receive valid to user logic |
| rx_out_last | output | 1 | Receive last to user logic |
| evt_fp | output | 20 | Fingerprint of the oldest FIFO entry |
| evt_time | output | TS_W | Timestamp of the oldest FIFO entry |
| evt_pop | input | 1 | Remove the oldest FIFO entry |
| evt_irq | output | 1 | Level interrupt: FIFO not empty |
| evt_ovf | output | 1 | Sticky overflow flag |
| evt_ovf_clr | input | 1 | Clear the overflow flag |

## Verification
The bench builds the block with its default parameters: a four-entry FIFO and a 64-bit timestamp. With only four entries, the full boundary, the dropped fifth entry and the ordered drain can all be reached with a handful of frames. Transmit frames are swept over all sixteen type nibbles in both stamp modes, and receive frames over all sixteen types. Expected requests, fingerprints and FIFO contents are computed from the type, the byte position and a sequence number derived from the loop index. A stalled transmit run checks that the byte-48 boundary holds when the MAC withholds ready.

// File: rtl/ptp_tag_pkg.sv
package ptp_tag_pkg;

   localparam int unsigned ETH_HDR_BYTES = 14;
   localparam int unsigned PTP_HDR_BYTES = 34;
   localparam int unsigned PTP_SEQ_OFS   = 30;
   localparam int unsigned FP_W          = 20;

   typedef enum logic [3:0] {
      MSG_SYNC     = 4'h0,
      MSG_DLY_REQ  = 4'h1,
      MSG_FUP      = 4'h8,
      MSG_DLY_RESP = 4'h9
   } ptp_msg_e;

   typedef struct packed {
      logic [3:0]  kind;
      logic [15:0] seq;
   } ptp_fp_t;

   // Decide whether a frame wants a hardware stamp.
   function automatic logic wants_stamp(logic is_ptp, logic [3:0] kind, logic all_mode);
      logic resp;
      resp = is_ptp && (kind == MSG_DLY_RESP);
      return all_mode ? !resp : (is_ptp && !resp);
   endfunction

endpackage

// File: rtl/ptp_frame_parse.sv
module ptp_frame_parse
   import ptp_tag_pkg::*;
#(
   parameter logic [15:0] ETYPE = 16'h88F7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       beat,
   input  logic [7:0] data,
   input  logic       last,
   output logic       hdr_done,
   output logic       is_ptp,
   output ptp_fp_t    fp
);

   localparam int unsigned HDR_END  = ETH_HDR_BYTES + PTP_HDR_BYTES;
   localparam int unsigned IDX_W    = $clog2(HDR_END + 1);
   localparam int unsigned ET_HI    = ETH_HDR_BYTES - 2;
   localparam int unsigned ET_LO    = ETH_HDR_BYTES - 1;
   localparam int unsigned TYPE_POS = ETH_HDR_BYTES;
   localparam int unsigned SEQ_POS  = ETH_HDR_BYTES + PTP_SEQ_OFS;

   if (SEQ_POS + 1 >= HDR_END) begin : g_bad_layout
      $error("sequence field must lie inside the header");
   end

   logic [IDX_W-1:0] idx;
   logic [7:0]       et_hi;
   logic             et_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx   <= '0;
         et_hi <= '0;
         et_ok <= 1'b0;
         fp    <= '0;
      end else if (beat) begin
         if (last) begin
            idx   <= '0;
            et_ok <= 1'b0;
            fp    <= '0;
         end else begin
            if (idx != IDX_W'(HDR_END)) idx <= idx + 1'b1;
            if (idx == IDX_W'(ET_HI))    et_hi <= data;
            if (idx == IDX_W'(ET_LO))    et_ok <= ({et_hi, data} == ETYPE);
            if (idx == IDX_W'(TYPE_POS)) fp.kind <= data[3:0];
            if (idx == IDX_W'(SEQ_POS))  fp.seq[15:8] <= data;
            if (idx == IDX_W'(SEQ_POS + 1)) fp.seq[7:0] <= data;
         end
      end
   end

   assign hdr_done = (idx == IDX_W'(HDR_END));
   assign is_ptp   = et_ok;

   // R11
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat |=> $stable(idx));

   // R4
   hdr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_done && !(beat && last) |=> hdr_done && $stable(fp));

endmodule

// File: rtl/ptp_ts_fifo.sv
module ptp_ts_fifo #(
   parameter int unsigned W     = 84,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_ptr, rd_ptr;
   logic         do_push, do_pop;

   assign empty   = (wr_ptr == rd_ptr);
   assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr[AW-1:0]] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // R10
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && push && !pop |=> full && $stable(dout));

   // R8
   pop_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop && !empty && !push |=> !full);

endmodule

// File: rtl/ptp_tagger.sv
module ptp_tagger
   import ptp_tag_pkg::*;
#(
   parameter logic [15:0] PTP_ETYPE  = 16'h88F7,
   parameter int unsigned TS_W       = 64,
   parameter int unsigned FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_stamp_all,
   input  logic [7:0]        tx_in_data,
   input  logic              tx_in_valid,
   input  logic              tx_in_last,
   output logic              tx_in_ready,
   output logic [7:0]        tx_out_data,
   output logic              tx_out_valid,
   output logic              tx_out_last,
   input  logic              tx_out_ready,
   output logic              tx_fp_valid,
   output logic [FP_W-1:0]   tx_fp,
   output logic              tx_ts_req,
   input  logic [7:0]        rx_in_data,
   input  logic              rx_in_valid,
   input  logic              rx_in_last,
   input  logic [TS_W-1:0]   rx_ts,
   output logic [7:0]        rx_out_data,
   output logic              rx_out_valid,
   output logic              rx_out_last,
   output logic [FP_W-1:0]   evt_fp,
   output logic [TS_W-1:0]   evt_time,
   input  logic              evt_pop,
   output logic              evt_irq,
   output logic              evt_ovf,
   input  logic              evt_ovf_clr
);

   localparam int unsigned ENT_W = FP_W + TS_W;
   localparam int unsigned NDIR  = 2;
   localparam int unsigned D_TX  = 0;
   localparam int unsigned D_RX  = 1;

   if (TS_W < 1) begin : g_bad_ts
      $error("TS_W must be at least 1");
   end

   // pass-through
   assign tx_out_data  = tx_in_data;
   assign tx_out_valid = tx_in_valid;
   assign tx_out_last  = tx_in_last;
   assign tx_in_ready  = tx_out_ready;
   assign rx_out_data  = rx_in_data;
   assign rx_out_valid = rx_in_valid;
   assign rx_out_last  = rx_in_last;

   logic       beat_v [NDIR];
   logic [7:0] data_v [NDIR];
   logic       last_v [NDIR];
   logic       hdr_v  [NDIR];
   logic       ptp_v  [NDIR];
   ptp_fp_t    fp_v   [NDIR];

   assign beat_v[D_TX] = tx_in_valid && tx_out_ready;
   assign data_v[D_TX] = tx_in_data;
   assign last_v[D_TX] = tx_in_last;
   assign beat_v[D_RX] = rx_in_valid;
   assign data_v[D_RX] = rx_in_data;
   assign last_v[D_RX] = rx_in_last;

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      ptp_frame_parse #(.ETYPE(PTP_ETYPE)) u_parse (
         .clk      (clk),
         .rst_n    (rst_n),
         .beat     (beat_v[d]),
         .data     (data_v[d]),
         .last     (last_v[d]),
         .hdr_done (hdr_v[d]),
         .is_ptp   (ptp_v[d]),
         .fp       (fp_v[d])
      );
   end

   // transmit decisions
   assign tx_fp_valid = hdr_v[D_TX] && ptp_v[D_TX];
   assign tx_fp       = tx_fp_valid ? fp_v[D_TX] : '0;
   assign tx_ts_req   = hdr_v[D_TX] && wants_stamp(ptp_v[D_TX], fp_v[D_TX].kind, tx_stamp_all);

   // receive capture
   logic            rx_mid;
   logic [TS_W-1:0] rx_ts_q;
   logic            rx_push;
   logic            fifo_empty, fifo_full;
   logic [ENT_W-1:0] fifo_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_mid  <= 1'b0;
         rx_ts_q <= '0;
      end else if (rx_in_valid) begin
         rx_mid <= !rx_in_last;
         if (!rx_mid) rx_ts_q <= rx_ts;
      end
   end

   assign rx_push = rx_in_valid && rx_in_last && hdr_v[D_RX] &&
                    wants_stamp(ptp_v[D_RX], fp_v[D_RX].kind, 1'b0);

   ptp_ts_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .pop   (evt_pop),
      .din   ({fp_v[D_RX], rx_ts_q}),
      .dout  (fifo_out),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   assign evt_fp   = fifo_out[ENT_W-1:TS_W];
   assign evt_time = fifo_out[TS_W-1:0];
   assign evt_irq  = !fifo_empty;

   always_ff @(posedge clk) begin
      if (!rst_n)                     evt_ovf <= 1'b0;
      else if (rx_push && fifo_full)  evt_ovf <= 1'b1;
      else if (evt_ovf_clr)           evt_ovf <= 1'b0;
   end

   // R4
   tx_fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fp_valid && !(tx_in_valid && tx_out_ready && tx_in_last)
      |=> tx_fp_valid && $stable(tx_fp));

   // R5
   tx_resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fp_valid && tx_fp[FP_W-1:FP_W-4] == MSG_DLY_RESP |-> !tx_ts_req);

   // R9
   irq_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> evt_irq);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ovf && !evt_ovf_clr |=> evt_ovf);

   // R7
   push_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_mid);

endmodule

// File: tb/ptp_tagger_test.sv
module ptp_tagger_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tx_stamp_all;
   logic [7:0]  tx_in_data;
   logic        tx_in_valid, tx_in_last, tx_in_ready;
   logic [7:0]  tx_out_data;
   logic        tx_out_valid, tx_out_last, tx_out_ready;
   logic        tx_fp_valid;
   logic [19:0] tx_fp;
   logic        tx_ts_req;
   logic [7:0]  rx_in_data;
   logic        rx_in_valid, rx_in_last;
   logic [63:0] rx_ts;
   logic [7:0]  rx_out_data;
   logic        rx_out_valid, rx_out_last;
   logic [19:0] evt_fp;
   logic [63:0] evt_time;
   logic        evt_pop, evt_irq, evt_ovf, evt_ovf_clr;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   ptp_tagger uut (
      .clk(clk), .rst_n(rst_n), .tx_stamp_all(tx_stamp_all),
      .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_last(tx_in_last),
      .tx_in_ready(tx_in_ready), .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid),
      .tx_out_last(tx_out_last), .tx_out_ready(tx_out_ready), .tx_fp_valid(tx_fp_valid),
      .tx_fp(tx_fp), .tx_ts_req(tx_ts_req), .rx_in_data(rx_in_data),
      .rx_in_valid(rx_in_valid), .rx_in_last(rx_in_last), .rx_ts(rx_ts),
      .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid), .rx_out_last(rx_out_last),
      .evt_fp(evt_fp), .evt_time(evt_time), .evt_pop(evt_pop), .evt_irq(evt_irq),
      .evt_ovf(evt_ovf), .evt_ovf_clr(evt_ovf_clr)
   );

   task automatic chk(input bit ok, input string req, input logic [83:0] act, input logic [83:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] fbyte(int i, bit ptp, logic [3:0] k, logic [15:0] s);
      if (i == 12) return ptp ? 8'h88 : 8'h08;
      if (i == 13) return ptp ? 8'hF7 : 8'h00;
      if (i == 14) return {4'h5, k};
      if (i == 44) return s[15:8];
      if (i == 45) return s[7:0];
      return 8'(i * 7 + 3);
   endfunction

   task automatic send_tx(input bit ptp, input logic [3:0] k, input logic [15:0] s,
                          input int len, input bit all, input bit stall);
      tx_stamp_all = all;
      for (int i = 0; i < len; i++) begin
         bit taken = 0;
         int w = 0;
         bit exp_req, exp_fpv;
         tx_in_data  = fbyte(i, ptp, k, s);
         tx_in_valid = 1'b1;
         tx_in_last  = (i == len - 1);
         while (!taken) begin
            tx_out_ready = stall ? (w % 3 == 2) : 1'b1;
            #1;
            exp_fpv = (i >= 48) && ptp;
            exp_req = (i >= 48) && (all ? !(ptp && k == 4'h9) : (ptp && k != 4'h9));
            chk(tx_out_data == tx_in_data && tx_out_valid && tx_out_last == tx_in_last &&
                tx_in_ready == tx_out_ready, "R1", {tx_out_data, tx_out_valid, tx_out_last},
                {tx_in_data, 1'b1, tx_in_last});
            // R5 / R6, with R11 when stalled
            chk(tx_ts_req == exp_req, stall ? "R11" : (all ? "R6" : "R5"), tx_ts_req, exp_req);
            chk(tx_fp_valid == exp_fpv, stall ? "R11" : "R4", tx_fp_valid, exp_fpv);
            if (exp_fpv) chk(tx_fp == {k, s}, "R3", tx_fp, {k, s});
            @(posedge clk);
            taken = tx_out_ready;
            w++;
            @(negedge clk);
         end
      end
      tx_in_valid = 1'b0;
      tx_in_last  = 1'b0;
      #1;
      chk(!tx_fp_valid && tx_fp == 20'h0, "R4", {tx_fp_valid, tx_fp}, 0);
      chk(!tx_ts_req, "R5", tx_ts_req, 0);
      @(negedge clk);
   endtask

   task automatic send_rx(input bit ptp, input logic [3:0] k, input logic [15:0] s,
                          input int len, input logic [63:0] ts);
      for (int i = 0; i < len; i++) begin
         rx_in_data  = fbyte(i, ptp, k, s);
         rx_in_valid = 1'b1;
         rx_in_last  = (i == len - 1);
         rx_ts       = (i == 0) ? ts : ~ts + 64'(i);
         #1;
         chk(rx_out_data == rx_in_data && rx_out_valid && rx_out_last == rx_in_last, "R2",
             {rx_out_data, rx_out_last}, {rx_in_data, rx_in_last});
         @(posedge clk);
         @(negedge clk);
      end
      rx_in_valid = 1'b0;
      rx_in_last  = 1'b0;
      #1;
   endtask

   task automatic pop_one();
      @(negedge clk);
      evt_pop = 1'b1;
      @(posedge clk);
      @(negedge clk);
      evt_pop = 1'b0;
      #1;
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      tx_stamp_all = 1'b0; tx_in_data = '0; tx_in_valid = 1'b0; tx_in_last = 1'b0;
      tx_out_ready = 1'b1; rx_in_data = '0; rx_in_valid = 1'b0; rx_in_last = 1'b0;
      rx_ts = '0; evt_pop = 1'b0; evt_ovf_clr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!evt_irq, "R9", evt_irq, 0);
      chk(!evt_ovf, "R10", evt_ovf, 0);
      chk(!tx_fp_valid && !tx_ts_req, "R4", {tx_fp_valid, tx_ts_req}, 0);
      @(negedge clk);

      // transmit sweep: both modes, all type nibbles, plus non-PTP
      for (int m = 0; m < 2; m++) begin
         for (int k = 0; k < 16; k++)
            send_tx(1'b1, 4'(k), 16'(16'h0100 + k * 257 + m), 60, m[0], 1'b0);
         send_tx(1'b0, 4'h0, 16'h1234, 60, m[0], 1'b0);
      end
      // R11: stalled frames
      send_tx(1'b1, 4'h0, 16'hBEEF, 52, 1'b0, 1'b1);
      send_tx(1'b1, 4'h9, 16'hCAFE, 52, 1'b1, 1'b1);

      // receive sweep
      for (int k = 0; k < 16; k++) begin
         logic [63:0] ts;
         logic [15:0] s;
         ts = 64'h0123_4567_0000_0000 + 64'(k * 1000);
         s  = 16'(16'h2000 + k * 31);
         send_rx(1'b1, 4'(k), s, 60, ts);
         chk(evt_irq == (k != 9), "R7", evt_irq, (k != 9));
         if (k != 9) begin
            chk({evt_fp, evt_time} == {4'(k), s, ts}, "R7", {evt_fp, evt_time}, {4'(k), s, ts});
            pop_one();
            chk(!evt_irq, "R9", evt_irq, 0);
         end
         @(negedge clk);
      end
      send_rx(1'b0, 4'h0, 16'h5555, 60, 64'h77);
      chk(!evt_irq, "R7", evt_irq, 0);
      send_rx(1'b1, 4'h0, 16'h6666, 40, 64'h88);
      chk(!evt_irq, "R7", evt_irq, 0);
      @(negedge clk);

      // R10 / R8: fill, overflow, ordered drain
      for (int j = 0; j < 5; j++) begin
         send_rx(1'b1, 4'h1, 16'(16'h3000 + j), 60, 64'(64'hA000 + j * 3));
         if (j == 3) chk(evt_irq && !evt_ovf, "R10", {evt_irq, evt_ovf}, 2'b10);
         if (j == 4) chk(evt_ovf, "R10", evt_ovf, 1);
         @(negedge clk);
      end
      for (int j = 0; j < 4; j++) begin
         chk(evt_irq, "R9", evt_irq, 1);
         chk({evt_fp, evt_time} == {4'h1, 16'(16'h3000 + j), 64'(64'hA000 + j * 3)}, "R8",
             {evt_fp, evt_time}, {4'h1, 16'(16'h3000 + j), 64'(64'hA000 + j * 3)});
         pop_one();
      end
      chk(!evt_irq, "R9", evt_irq, 0);
      chk(evt_ovf, "R10", evt_ovf, 1);
      @(negedge clk);
      evt_ovf_clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      evt_ovf_clr = 1'b0;
      #1;
      chk(!evt_ovf, "R10", evt_ovf, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule